// File: doc/BRIEF.md
# Timer Compare Channel with Mode-Dependent Buffering

This block is one compare channel of an 8-bit timer. A counter advances on every cycle in which the timer clock enable is high. The counter is compared against an active compare value. A hit sets a sticky flag and drives an output pin according to a 2-bit action field. Software reaches the channel through a single write port with four addresses: counter, compare value, control and flag clear.

Three waveform modes are selected by the control register.
- In free-running mode the counter wraps from all-ones to zero.
- In clear-on-match mode a hit returns the counter to zero.
- In fast-PWM mode the pin is driven at the wrap point and at the hit. Compare writes are held in a shadow register and reach the active value only when the counter passes its top value. This keeps every period whole.

Software can also force a hit on the pin. Any write to the counter masks the next hit, so a counter can be preset equal to the compare value without an unwanted event.

Top module: `ocmp_channel`

## Requirements
- R1: After reset the counter, the active compare value, the pin and the flag are all zero, and the mode is free-running with the hold action.
- R2: Write addresses: 0 counter, 1 compare, 2 control, 3 flag clear. Control bits [1:0] select the mode: 00 free-running, 01 clear-on-match, 10 fast-PWM, 11 behaves as free-running. In free-running mode the counter rises by one on each enabled tick, wraps from 0xFF to 0x00, and holds when the tick enable is low.
- R3: A hit is an enabled tick on which counter equals active compare and no masking applies. A hit sets the flag on that edge. Writing data bit 0 = 1 to address 3 clears the flag. A hit in the same cycle wins over the clear.
- R4: In clear-on-match mode the counter is loaded with zero on a hit tick instead of incrementing.
- R5: In non-PWM modes, control bits [3:2] give the action on a hit: 00 hold, 01 toggle, 10 drive low, 11 drive high.
- R6: In non-PWM modes a compare write replaces the active compare value on that edge.
- R7: In fast-PWM mode a compare write only fills the shadow register. The active value is loaded from the shadow on an enabled tick where the counter is 0xFF.
- R8: In fast-PWM mode with action 10, a hit drives the pin low and the 0xFF tick drives it high. Action 11 does the opposite, and actions 00 and 01 hold. When a hit falls on the 0xFF tick, the wrap action wins.
- R9: A control write with data bit 7 set, whose written mode is not fast-PWM, applies the written action to the pin once. It leaves the flag and the counter untouched. A forced hit and a real hit in the same cycle act once. With a written fast-PWM mode the force is ignored.
- R10: A counter write loads the value on that edge and masks the hit of the first enabled tick after it, however many idle cycles pass in between. A tick in the same cycle as the counter write is also matchless.
- R11: The pin keeps its level when the mode or action changes. A new action governs the next event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable, gates all counting |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 counter, 1 compare, 2 control, 3 flag clear) |
| wr_data | input | W | Write data |
| cnt_o | output | W | Counter value |
| cmp_o | output | W | Active compare value |
| oc_o | output | 1 | Compare output pin |
| flag_o | output | 1 | Sticky compare flag |

## Verification
Two pairs of events can share one cycle.

The first pair is a forced hit and a real hit. The bench presets the counter one below the compare value, ticks once, and then issues a toggle-force write together with the hit tick. One toggle is expected, and the flag is expected to be set by the real hit only.

The second pair is a fast-PWM hit and the wrap event. The bench loads 0xFF through the shadow register and runs across the top. It expects the pin level of the wrap action and the flag to be set. Masking is judged the same way: a counter write that coincides with a hitting tick must leave the flag clear.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_CLR  = 2'b01,
        MODE_PWM  = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } act_e;

    localparam logic [1:0] ADDR_CNT  = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam logic [1:0] ADDR_CTL  = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;

    localparam int CTL_FORCE_BIT = 7;

endpackage

// File: rtl/ocmp_counter.sv
module ocmp_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         blank,
    output logic         at_top
);

    localparam logic [W-1:0] TOP_VAL = '1;
    localparam logic [W-1:0] INC     = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            blank <= 1'b0;
        end else if (ld) begin
            cnt   <= ld_val;
            blank <= 1'b1;
        end else if (tick) begin
            blank <= 1'b0;
            cnt   <= clr ? '0 : cnt + INC;
        end
    end

    assign at_top = (cnt == TOP_VAL);

    AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && !tick && !ld) |=> blank); // R10

endmodule

// File: rtl/ocmp_cmpreg.sv
module ocmp_cmpreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wr_val,
    input  logic         buffered,
    input  logic         load,
    output logic [W-1:0] active
);

    logic [W-1:0] shadow;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            active <= '0;
        end else begin
            if (wr)
                shadow <= wr_val;
            if (wr && !buffered)
                active <= wr_val;
            else if (load)
                active <= shadow;
        end
    end

    AST_SHADOW_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered && !load) |=> $stable(active)); // R7

endmodule

// File: rtl/ocmp_wave.sv
module ocmp_wave
    import ocmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic top_evt,
    input  logic pwm,
    input  act_e act,
    input  logic force_req,
    input  act_e force_act,
    input  logic flag_clr,
    output logic oc,
    output logic flag
);

    function automatic logic apply_act(input act_e a, input logic cur);
        logic r;
        unique case (a)
            ACT_HOLD:   r = cur;
            ACT_TOGGLE: r = ~cur;
            ACT_LOW:    r = 1'b0;
            ACT_HIGH:   r = 1'b1;
        endcase
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc <= 1'b0;
        end else if (force_req) begin
            oc <= apply_act(force_act, oc);
        end else if (pwm) begin
            if (top_evt) begin
                unique case (act)
                    ACT_LOW:  oc <= 1'b1;
                    ACT_HIGH: oc <= 1'b0;
                    default:  oc <= oc;
                endcase
            end else if (match) begin
                unique case (act)
                    ACT_LOW:  oc <= 1'b0;
                    ACT_HIGH: oc <= 1'b1;
                    default:  oc <= oc;
                endcase
            end
        end else if (match) begin
            oc <= apply_act(act, oc);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (match)
            flag <= 1'b1;
        else if (flag_clr)
            flag <= 1'b0;
    end

    AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag); // R3
    AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (force_req && !match && !flag) |=> !flag); // R9

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cmp_o,
    output logic         oc_o,
    output logic         flag_o
);

    mode_e mode_q;
    act_e  act_q;

    logic wr_cnt, wr_cmp, wr_ctl, wr_flag;
    logic blank, at_top, match, top_evt, pwm, clr, force_req;
    mode_e wr_mode;
    act_e  wr_act;

    assign wr_cnt  = wr_en && (wr_addr == ADDR_CNT);
    assign wr_cmp  = wr_en && (wr_addr == ADDR_CMP);
    assign wr_ctl  = wr_en && (wr_addr == ADDR_CTL);
    assign wr_flag = wr_en && (wr_addr == ADDR_FLAG) && wr_data[0];
    assign wr_mode = mode_e'(wr_data[1:0]);
    assign wr_act  = act_e'(wr_data[3:2]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_FREE;
            act_q  <= ACT_HOLD;
        end else if (wr_ctl) begin
            mode_q <= wr_mode;
            act_q  <= wr_act;
        end
    end

    assign pwm       = (mode_q == MODE_PWM);
    assign match     = tick && !wr_cnt && !blank && (cnt_o == cmp_o);
    assign top_evt   = tick && !wr_cnt && pwm && at_top;
    assign clr       = match && (mode_q == MODE_CLR);
    assign force_req = wr_ctl && wr_data[CTL_FORCE_BIT] && (wr_mode != MODE_PWM);

    ocmp_counter #(.W(W)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .ld     (wr_cnt),
        .ld_val (wr_data),
        .clr    (clr),
        .cnt    (cnt_o),
        .blank  (blank),
        .at_top (at_top)
    );

    ocmp_cmpreg #(.W(W)) u_cmpreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_cmp),
        .wr_val   (wr_data),
        .buffered (pwm),
        .load     (top_evt),
        .active   (cmp_o)
    );

    ocmp_wave u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .match     (match),
        .top_evt   (top_evt),
        .pwm       (pwm),
        .act       (act_q),
        .force_req (force_req),
        .force_act (wr_act),
        .flag_clr  (wr_flag),
        .oc        (oc_o),
        .flag      (flag_o)
    );

    AST_CLR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode_q == MODE_CLR) |=> (cnt_o == '0)); // R4
    AST_DIRECT_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmp && !pwm) |=> (cmp_o == $past(wr_data))); // R6
    AST_MASKED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && tick && !flag_o) |=> !flag_o); // R10
    AST_PIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !wr_data[CTL_FORCE_BIT] && !match && !top_evt) |=> $stable(oc_o)); // R11

endmodule

// File: tb/ocmp_channel_bench.sv
`timescale 1ns/1ps
module ocmp_channel_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] cnt_o, cmp_o;
    logic         oc_o, flag_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [3:0] m;
        logic [7:0] c;
        logic [7:0] k;
        logic       o;
        logic       f;
    } exp_t;

    exp_t  q[$];
    string tq[$];

    always #2.5 clk = ~clk;

    ocmp_channel #(.W(W)) u_ocmp_channel (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_o(cnt_o), .cmp_o(cmp_o), .oc_o(oc_o), .flag_o(flag_o)
    );

    // monitor: pops one expectation per falling edge and compares
    always @(negedge clk) begin
        if (q.size() != 0) begin
            exp_t  e;
            string tg;
            logic  bad;
            e  = q.pop_front();
            tg = tq.pop_front();
            checks++;
            bad = (e.m[3] && cnt_o !== e.c) || (e.m[2] && cmp_o !== e.k) ||
                  (e.m[1] && oc_o !== e.o) || (e.m[0] && flag_o !== e.f);
            if (bad) begin
                errors++;
                $display("FAIL %s cnt=%h/%h cmp=%h/%h oc=%b/%b flag=%b/%b (actual/expected)",
                         tg, cnt_o, e.c, cmp_o, e.k, oc_o, e.o, flag_o, e.f);
            end
        end
    end

    task automatic step(input logic t, input logic w, input logic [1:0] a, input logic [7:0] d);
        tick = t; wr_en = w; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic expect_it(input string tag, input logic [3:0] m, input logic [7:0] c,
                             input logic [7:0] k, input logic o, input logic f);
        exp_t e;
        e = '{m: m, c: c, k: k, o: o, f: f};
        q.push_back(e);
        tq.push_back(tag);
        wait (q.size() == 0);
    endtask

    // preset counter 7 then two ticks: hit at 8 (active compare 8)
    task automatic hit();
        step(0, 1, 2'd0, 8'h07);
        step(1, 0, 2'd0, 8'h00);
        step(1, 0, 2'd0, 8'h00);
    endtask

    task automatic wrap_top();
        step(0, 1, 2'd0, 8'hFE);
        step(1, 0, 2'd0, 8'h00);
        step(1, 0, 2'd0, 8'h00);
    endtask

    task automatic reach_40();
        step(0, 1, 2'd0, 8'h3F);
        step(1, 0, 2'd0, 8'h00);
        step(1, 0, 2'd0, 8'h00);
    endtask

    task automatic clr_flag();
        step(0, 1, 2'd3, 8'h01);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_it("R1 reset state", 4'hF, 8'h00, 8'h00, 1'b0, 1'b0);

        // free-running, compare, flag
        step(0, 1, 2'd0, 8'h05);
        expect_it("R10 counter write loads", 4'h8, 8'h05, 8'h00, 1'b0, 1'b0);
        step(1, 0, 2'd0, 8'h00);
        step(0, 1, 2'd1, 8'h08);
        expect_it("R6 direct compare write", 4'hC, 8'h06, 8'h08, 1'b0, 1'b0);
        step(0, 0, 2'd0, 8'h00);
        expect_it("R2 holds without tick", 4'h8, 8'h06, 8'h00, 1'b0, 1'b0);
        step(1, 0, 2'd0, 8'h00);
        step(1, 0, 2'd0, 8'h00);
        expect_it("R2 increments per tick", 4'h9, 8'h08, 8'h00, 1'b0, 1'b0);
        step(1, 0, 2'd0, 8'h00);
        expect_it("R3 hit sets flag", 4'hB, 8'h09, 8'h00, 1'b0, 1'b1);
        clr_flag();
        expect_it("R3 flag cleared by write", 4'h1, 8'h00, 8'h00, 1'b0, 1'b0);
        hit();
        step(0, 1, 2'd0, 8'h07);
        step(1, 0, 2'd0, 8'h00);
        step(1, 1, 2'd3, 8'h01);
        expect_it("R3 hit beats clear", 4'h1, 8'h00, 8'h00, 1'b0, 1'b1);
        clr_flag();
        wrap_top();
        expect_it("R2 wraps to zero", 4'h9, 8'h00, 8'h00, 1'b0, 1'b0);

        // output actions in free-running mode
        step(0, 1, 2'd2, 8'h04);
        hit();
        expect_it("R5 toggle", 4'hB, 8'h09, 8'h00, 1'b1, 1'b1);
        clr_flag();
        step(0, 1, 2'd2, 8'h08);
        hit();
        expect_it("R5 drive low", 4'h2, 8'h00, 8'h00, 1'b0, 1'b0);
        step(0, 1, 2'd2, 8'h0C);
        hit();
        expect_it("R5 drive high", 4'h2, 8'h00, 8'h00, 1'b1, 1'b0);
        step(0, 1, 2'd2, 8'h00);
        hit();
        expect_it("R5 hold", 4'h2, 8'h00, 8'h00, 1'b1, 1'b0);
        clr_flag();

        // masking after a counter write
        step(0, 1, 2'd2, 8'h04);
        step(0, 1, 2'd0, 8'h08);
        step(0, 0, 2'd0, 8'h00);
        step(0, 0, 2'd0, 8'h00);
        step(0, 0, 2'd0, 8'h00);
        step(1, 0, 2'd0, 8'h00);
        expect_it("R10 masked after idle cycles", 4'hB, 8'h09, 8'h00, 1'b1, 1'b0);
        hit();
        expect_it("R10 mask lasts one tick", 4'hB, 8'h09, 8'h00, 1'b0, 1'b1);
        clr_flag();
        step(0, 1, 2'd0, 8'h07);
        step(1, 0, 2'd0, 8'h00);
        step(1, 1, 2'd0, 8'h30);
        expect_it("R10 write with hitting tick", 4'hB, 8'h30, 8'h00, 1'b0, 1'b0);
        step(1, 0, 2'd0, 8'h00);

        // force
        step(0, 1, 2'd2, 8'h8C);
        expect_it("R9 force high", 4'hF, 8'h31, 8'h08, 1'b1, 1'b0);
        step(0, 1, 2'd2, 8'h84);
        expect_it("R9 force toggle", 4'hB, 8'h31, 8'h00, 1'b0, 1'b0);
        step(0, 1, 2'd0, 8'h07);
        step(1, 0, 2'd0, 8'h00);
        step(1, 1, 2'd2, 8'h84);
        expect_it("R9 force with hit acts once", 4'hB, 8'h09, 8'h00, 1'b1, 1'b1);
        step(0, 1, 2'd2, 8'h86);
        expect_it("R9 force ignored in PWM", 4'hA, 8'h09, 8'h00, 1'b1, 1'b0);
        clr_flag();

        // clear-on-match
        step(0, 1, 2'd2, 8'h01);
        step(0, 1, 2'd0, 8'h06);
        step(1, 0, 2'd0, 8'h00);
        step(1, 0, 2'd0, 8'h00);
        step(1, 0, 2'd0, 8'h00);
        expect_it("R4 counter cleared on hit", 4'hB, 8'h00, 8'h00, 1'b1, 1'b1);
        step(1, 0, 2'd0, 8'h00);
        expect_it("R4 counts on from zero", 4'h8, 8'h01, 8'h00, 1'b0, 1'b0);
        clr_flag();

        // fast PWM
        step(0, 1, 2'd2, 8'h0A);
        expect_it("R11 pin kept on mode change", 4'h2, 8'h00, 8'h00, 1'b1, 1'b0);
        step(0, 1, 2'd1, 8'h40);
        expect_it("R7 write held in shadow", 4'h4, 8'h00, 8'h08, 1'b0, 1'b0);
        wrap_top();
        expect_it("R7 shadow loaded at top", 4'hE, 8'h00, 8'h40, 1'b1, 1'b0);
        reach_40();
        expect_it("R8 hit drives low", 4'hB, 8'h41, 8'h00, 1'b0, 1'b1);
        wrap_top();
        expect_it("R8 wrap drives high", 4'hA, 8'h00, 8'h00, 1'b1, 1'b0);
        step(0, 1, 2'd2, 8'h0E);
        wrap_top();
        expect_it("R8 inverted wrap drives low", 4'h2, 8'h00, 8'h00, 1'b0, 1'b0);
        reach_40();
        expect_it("R8 inverted hit drives high", 4'h2, 8'h00, 8'h00, 1'b1, 1'b0);
        step(0, 1, 2'd2, 8'h0A);
        clr_flag();
        step(0, 1, 2'd1, 8'hFF);
        expect_it("R7 active unchanged before top", 4'h4, 8'h00, 8'h40, 1'b0, 1'b0);
        wrap_top();
        expect_it("R7 top loads 0xFF", 4'h7, 8'h00, 8'hFF, 1'b1, 1'b0);
        wrap_top();
        expect_it("R8 wrap wins over hit", 4'hB, 8'h00, 8'h00, 1'b1, 1'b1);

        // back to free-running
        step(0, 1, 2'd2, 8'h00);
        expect_it("R11 pin kept leaving PWM", 4'h2, 8'h00, 8'h00, 1'b1, 1'b0);
        step(0, 1, 2'd1, 8'h10);
        expect_it("R6 direct write after PWM", 4'h4, 8'h00, 8'h10, 1'b0, 1'b0);

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule